// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Chain

This block links a row of peripheral interface cells that all raise interrupts at one shared priority level. Each cell holds a pending flag and an 8-bit vector register, which gives 256 possible vector values. The pending flags are ORed into a single shared request line toward the processor. When the processor answers with an acknowledge, the acknowledge enters the cell nearest the processor (index 0) and moves down the row. The first cell that has a pending request keeps the acknowledge and puts its own vector on the data bus. That vector tells the processor which handler to run. Cells with nothing pending pass the acknowledge on unchanged, so a cell's priority is set only by where it sits in the row.

The set of cells allowed to claim an acknowledge is fixed when the acknowledge rises. Requests that arrive while the acknowledge is high are recorded but cannot take the cycle away from the cell that already holds it. The cell that held the acknowledge clears its request at the first clock edge after the acknowledge falls. If the acknowledge runs off the far end of the row because no cell was eligible, the block places a fixed spurious-interrupt vector on the bus.

Top module: `irq_daisy_chain`

## Requirements
- R1: After reset, no cell is pending, `irq_out` is 0, `vec_valid` is 0 and `ack_tail` is 0.
- R2: A one-cycle pulse on `req_set[i]` makes cell i pending from the next clock edge on. `irq_out` is 1 whenever any cell is pending.
- R3: A cell that is not eligible passes the acknowledge through unchanged and drives nothing onto the vector bus.
- R4: While `ack_in` is 1, the eligible cell with the lowest index keeps the acknowledge. Its vector appears on `vec_out` in the same cycle, `vec_valid` is 1, and `ack_tail` is 0.
- R5: At most one cell drives the vector bus at any time.
- R6: At the first clock edge with `ack_in` at 0 after an acknowledge, the cell that held that acknowledge clears its pending flag. Every other pending cell stays pending.
- R7: If `ack_in` is 1 and no cell is eligible, `ack_tail` is 1, `vec_out` is 0x18 and `vec_valid` is 1.
- R8: Eligibility is set from the pending flags only at clock edges where `ack_in` is 0. A request raised while `ack_in` is 1 does not change the cell that holds the acknowledge. That request stays pending and is served by a later acknowledge.
- R9: A pulse on `vec_we[i]` loads `vec_wdata` into cell i's vector register at the next clock edge. Later acknowledges of that cell return the new value.
- R10: If a `req_set` pulse for the cell being cleared falls in the same cycle as the clearing edge, the set wins and the cell stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set | input | N_CELLS | Per-cell request pulse from the peripheral |
| vec_we | input | N_CELLS | Per-cell write strobe for the vector register |
| vec_wdata | input | 8 | Vector value to be written |
| ack_in | input | 1 | Acknowledge from the processor, entering cell 0 |
| irq_out | output | 1 | Shared request: OR of all pending flags |
| vec_out | output | 8 | Vector placed on the data bus during an acknowledge |
| vec_valid | output | 1 | 1 while `vec_out` holds a vector |
| ack_tail | output | 1 | Acknowledge leaving the last cell (no cell claimed it) |

## Verification
The bench tests acknowledges in five situations: with no request, with one request partway down the row, with two requests, with a request raised while an acknowledge is high, and with a request set on the same edge as the clear. The empty case separates the spurious path from a cell answering. The two-request case shows that position sets priority and that only the cell that held the acknowledge is cleared. The request raised mid-acknowledge shows that eligibility is frozen during the acknowledge. The same-edge case shows that a set wins over a clear. Rewriting a vector register and then acknowledging that cell shows that each cell supplies its own vector.

// File: rtl/irq_dc_pkg.sv
package irq_dc_pkg;
    localparam int unsigned DC_VEC_W = 8;

    typedef logic [DC_VEC_W-1:0] vec_t;

    typedef struct packed {
        logic pending;  // request waiting for service
        logic elig;     // snapshot used to claim the acknowledge
        logic taken;    // this cell held the acknowledge last cycle
        vec_t vec;      // vector register
    } cell_state_t;
endpackage

// File: rtl/irq_dc_cell.sv
module irq_dc_cell
    import irq_dc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic vec_we,
    input  vec_t vec_wdata,
    input  logic ack_in,
    output logic ack_out,
    output logic drv_en,
    output vec_t vec_drv,
    output logic pend_out
);
    cell_state_t st_d, st_q;
    logic        grab;

    always_comb begin
        grab     = ack_in & st_q.elig;
        ack_out  = ack_in & ~st_q.elig;
        drv_en   = grab;
        vec_drv  = grab ? st_q.vec : '0;
        pend_out = st_q.pending;

        st_d = st_q;
        if (vec_we) begin
            st_d.vec = vec_wdata;
        end
        if (req_set) begin
            st_d.pending = 1'b1;
        end else if (!ack_in && st_q.taken) begin
            st_d.pending = 1'b0;
        end
        st_d.taken = grab;
        if (!ack_in) begin
            st_d.elig = st_d.pending;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r2_set_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req_set |=> pend_out);

    a_r6_clear_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.taken && !ack_in && !req_set) |=> !pend_out);

    a_r8_frozen_elig: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in |=> $stable(st_q.elig));
endmodule

// File: rtl/irq_dc_bus.sv
module irq_dc_bus
    import irq_dc_pkg::*;
#(
    parameter int unsigned N_CELLS  = 4,
    parameter vec_t        SPUR_VEC = 8'h18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CELLS-1:0]          drv_en,
    input  logic [N_CELLS*DC_VEC_W-1:0] vec_bus,
    input  logic                        tail,
    output vec_t                        vec_out,
    output logic                        vec_valid
);
    vec_t merged;

    always_comb begin
        merged = '0;
        for (int i = 0; i < N_CELLS; i++) begin
            merged = merged | vec_bus[i*DC_VEC_W +: DC_VEC_W];
        end
        vec_out   = tail ? SPUR_VEC : merged;
        vec_valid = tail | (|drv_en);
    end

    a_r5_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en));

    a_r7_tail_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        tail |-> (drv_en == '0));
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
    import irq_dc_pkg::*;
#(
    parameter int unsigned N_CELLS  = 4,
    parameter logic [7:0]  SPUR_VEC = 8'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] req_set,
    input  logic [N_CELLS-1:0] vec_we,
    input  logic [7:0]         vec_wdata,
    input  logic               ack_in,
    output logic               irq_out,
    output logic [7:0]         vec_out,
    output logic               vec_valid,
    output logic               ack_tail
);
    localparam int unsigned BUS_W = N_CELLS * DC_VEC_W;

    logic [N_CELLS:0]   ack_w;
    logic [N_CELLS-1:0] drv_en;
    logic [N_CELLS-1:0] pend;
    logic [BUS_W-1:0]   vec_bus;

    assign ack_w[0] = ack_in;

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        irq_dc_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_set   (req_set[g]),
            .vec_we    (vec_we[g]),
            .vec_wdata (vec_wdata),
            .ack_in    (ack_w[g]),
            .ack_out   (ack_w[g+1]),
            .drv_en    (drv_en[g]),
            .vec_drv   (vec_bus[g*DC_VEC_W +: DC_VEC_W]),
            .pend_out  (pend[g])
        );
    end

    assign ack_tail = ack_w[N_CELLS];
    assign irq_out  = |pend;

    irq_dc_bus #(
        .N_CELLS  (N_CELLS),
        .SPUR_VEC (SPUR_VEC)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_en    (drv_en),
        .vec_bus   (vec_bus),
        .tail      (ack_w[N_CELLS]),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    a_r4_claim_blocks_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (|drv_en) |-> !ack_tail);
endmodule

// File: tb/irq_daisy_chain_tb.sv
module irq_daisy_chain_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_set = '0;
    logic [N-1:0] vec_we = '0;
    logic [7:0]   vec_wdata = '0;
    logic         ack_in = 1'b0;
    logic         irq_out, vec_valid, ack_tail;
    logic [7:0]   vec_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_daisy_chain #(.N_CELLS(N), .SPUR_VEC(8'h18)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .vec_we(vec_we),
        .vec_wdata(vec_wdata), .ack_in(ack_in), .irq_out(irq_out),
        .vec_out(vec_out), .vec_valid(vec_valid), .ack_tail(ack_tail)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #5;
    endtask

    task automatic pulse_req(input int idx);
        req_set[idx] = 1'b1;
        step();
        req_set[idx] = 1'b0;
    endtask

    task automatic write_vec(input int idx, input logic [7:0] v);
        vec_we[idx] = 1'b1;
        vec_wdata   = v;
        step();
        vec_we[idx] = 1'b0;
    endtask

    // Hold the acknowledge, check the vector, then drop it and step past the clear.
    task automatic ack_expect(input string req, input logic [7:0] exp_vec, input bit exp_tail);
        ack_in = 1'b1;
        settle();
        chk(req, vec_out, exp_vec);
        chk(req, vec_valid, 1);
        chk(req, ack_tail, exp_tail);
        step();
        ack_in = 1'b0;
        step();
    endtask

    task automatic t_reset();
        settle();
        chk("R1 irq", irq_out, 0);
        chk("R1 valid", vec_valid, 0);
        chk("R1 tail", ack_tail, 0);
    endtask

    task automatic t_spurious();
        ack_expect("R7 spurious", 8'h18, 1'b1);
        settle();
        chk("R7 irq stays low", irq_out, 0);
    endtask

    task automatic t_single();
        pulse_req(2);
        settle();
        chk("R2 irq raised", irq_out, 1);
        ack_expect("R3 R4 cell2", 8'h63, 1'b0);
        settle();
        chk("R6 cleared", irq_out, 0);
        chk("R4 bus idle after ack", vec_valid, 0);
    endtask

    task automatic t_two();
        req_set = 4'b1010;
        step();
        req_set = '0;
        ack_expect("R4 R5 nearest wins", 8'h52, 1'b0);
        settle();
        chk("R6 other stays pending", irq_out, 1);
        ack_expect("R3 R4 cell3 next", 8'h74, 1'b0);
        settle();
        chk("R6 all cleared", irq_out, 0);
    endtask

    task automatic t_mid_ack();
        pulse_req(3);
        ack_in = 1'b1;
        settle();
        chk("R8 cell3 holds", vec_out, 8'h74);
        step();
        pulse_req(0);
        settle();
        chk("R8 still cell3", vec_out, 8'h74);
        chk("R8 no tail", ack_tail, 0);
        ack_in = 1'b0;
        step();
        settle();
        chk("R8 late request kept", irq_out, 1);
        ack_expect("R8 late request served", 8'h41, 1'b0);
        settle();
        chk("R8 all served", irq_out, 0);
    endtask

    task automatic t_set_wins();
        pulse_req(1);
        ack_in = 1'b1;
        settle();
        chk("R10 cell1 held", vec_out, 8'h52);
        step();
        ack_in = 1'b0;
        req_set[1] = 1'b1;
        step();
        req_set[1] = 1'b0;
        settle();
        chk("R10 set wins", irq_out, 1);
        ack_expect("R10 served again", 8'h52, 1'b0);
        settle();
        chk("R10 finally clear", irq_out, 0);
    endtask

    task automatic t_rewrite();
        write_vec(1, 8'h99);
        pulse_req(1);
        ack_expect("R9 new vector", 8'h99, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        write_vec(0, 8'h41);
        write_vec(1, 8'h52);
        write_vec(2, 8'h63);
        write_vec(3, 8'h74);
        t_spurious();
        t_single();
        t_two();
        t_mid_ack();
        t_set_wins();
        t_rewrite();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule